// File: doc/BRIEF.md
# Peripheral Register Interface Controller

This block is the register front end of one peripheral on a simple system bus. The processor reaches four byte-wide registers through an address and a pair of read/write strobes. A command register starts a transfer. A word counter follows the words that move between an eight-entry buffer and the device. The status register reports completion, errors and a pending interrupt. The block raises `breq` while buffered inbound data waits for the bus, and raises `irq` when an operation ends normally or abnormally.

The pin `map_mem` selects the address decode. With `map_mem` low the block is port-mapped. It qualifies accesses only with `io_rd`/`io_wr` and compares only the low eight address bits. With `map_mem` high it is memory-mapped. It qualifies accesses only with `mem_rd`/`mem_wr` and compares every address bit against a reserved window.

The device side has two streams, both valid/ready. The inbound stream carries words into the buffer. `dev_in_ready` is high only while an inbound transfer is busy and the buffer has room. A word offered while ready is low is not taken: it is dropped, and it counts as an overrun if the buffer is full. The outbound stream presents the buffer head. A word moves on a cycle where both `dev_out_valid` and `dev_out_ready` are high, and `dev_out_data` holds steady until that happens.

Top module: `ioc_regif`

## Requirements
- R1: Registers sit at offsets 0 (command), 1 (count), 2 (status), 3 (data) of a four-byte block. In port mode the block is hit when bus_addr[7:2] equals PORT_BASE[7:2], and the upper address bits are ignored. In memory mode it is hit when bus_addr[15:2] equals MEM_BASE[15:2]. Read data is zero unless a register is read.
- R2: In port mode only io_rd/io_wr qualify an access and mem_rd/mem_wr have no effect. In memory mode the reverse holds, and an address outside the window has no effect.
- R3: The command register has these fields: [1:0] command (0 clear, 1 inbound, 2 outbound, 3 status check), [3:2] mode, [7:4] device number. dev_mode and dev_sel show the mode and device number. Writing the register while idle accepts it, flushes the buffer and clears done. A clear or check command sets the counter to zero. A check command also sets done and the interrupt.
- R4: An inbound or outbound command loads the counter from the last value written to offset 1. Reading offset 1 returns the counter. The counter drops by one per word the device moves (inbound push or outbound pull) while it is non-zero. On the first edge at which a busy transfer has a zero counter, busy clears and done and the interrupt set.
- R5: A device push while the buffer is full during an inbound transfer, or a data write while the buffer is full in outbound direction, loses the word and sets the sticky overrun, error and interrupt bits.
- R6: A data read in inbound direction from an empty buffer returns 0 and sets the sticky underrun, error and interrupt bits.
- R7: The status byte has these bits: bit0 dev_online, bit1 done, bit2 error, bit3 overrun, bit4 underrun, bit5 busy, bit6 zero, bit7 interrupt pending. irq equals bit7.
- R8: A status read clears the interrupt, error, overrun and underrun bits. An event in the same cycle still sets its bits.
- R9: A command write while busy is ignored (the command register is unchanged) and sets the error bit.
- R10: breq is high in inbound direction when the buffer holds at least 4 words, or when the counter is zero and the buffer is not empty. It is low otherwise.
- R11: A synchronous active-high rst clears every register, empties the buffer and drops irq and breq.
- R12: The buffer is first-in first-out. In inbound direction a data read returns the oldest word and removes it. In outbound direction a data write appends a word. dev_out_valid is high in outbound direction whenever the buffer is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| map_mem | input | 1 | 1 selects memory-mapped decode, 0 port-mapped |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data, valid while a read strobe is high |
| io_rd | input | 1 | Port-space read strobe |
| io_wr | input | 1 | Port-space write strobe |
| mem_rd | input | 1 | Memory-space read strobe |
| mem_wr | input | 1 | Memory-space write strobe |
| dev_online | input | 1 | Device reports online |
| dev_in_valid | input | 1 | Inbound word offered |
| dev_in_data | input | 8 | Inbound word |
| dev_in_ready | output | 1 | Inbound word will be taken |
| dev_out_valid | output | 1 | Outbound word available |
| dev_out_data | output | 8 | Outbound word (buffer head) |
| dev_out_ready | input | 1 | Device takes the outbound word |
| dev_sel | output | 4 | Device number from the command register |
| dev_mode | output | 2 | Mode field from the command register |
| breq | output | 1 | Bus request for buffered inbound data |
| irq | output | 1 | Interrupt pending |

## Verification
The bench drives the decode three ways: port mode with upper address bits set, memory mode with the wrong strobe family, and memory mode with an address outside the window. A register that changes in any of these cases shows a decoder fault. Transfers run inbound with back-to-back device words, and outbound with the processor overfilling the buffer before the device drains it. Counter stepping, done timing and `breq` thresholds are each seen rising and falling. The error paths include an overrun from each side, an underrun read, a rejected command while busy, a zero-count start and a reset taken with a full buffer. Together they separate sticky-flag faults from clear-on-read faults.

// File: rtl/ioc_pkg.sv
package ioc_pkg;
  localparam int unsigned NREG      = 4;
  localparam int unsigned OFF_CTRL  = 0;
  localparam int unsigned OFF_COUNT = 1;
  localparam int unsigned OFF_STAT  = 2;
  localparam int unsigned OFF_DATA  = 3;

  typedef enum logic [1:0] {
    CMD_CLEAR = 2'd0,
    CMD_IN    = 2'd1,
    CMD_OUT   = 2'd2,
    CMD_CHECK = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_IN   = 2'd1,
    DIR_OUT  = 2'd2
  } dir_e;

  localparam int unsigned ST_READY = 0;
  localparam int unsigned ST_DONE  = 1;
  localparam int unsigned ST_ERR   = 2;
  localparam int unsigned ST_OVR   = 3;
  localparam int unsigned ST_UNR   = 4;
  localparam int unsigned ST_BUSY  = 5;
  localparam int unsigned ST_IRQ   = 7;
endpackage

// File: rtl/ioc_addr_dec.sv
module ioc_addr_dec
  import ioc_pkg::*;
#(
  parameter int unsigned   AW        = 16,
  parameter int unsigned   PORT_AW   = 8,
  parameter logic [AW-1:0] PORT_BASE = 16'h0040,
  parameter logic [AW-1:0] MEM_BASE  = 16'hC000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            map_mem,
  input  logic [AW-1:0]   bus_addr,
  input  logic            io_rd,
  input  logic            io_wr,
  input  logic            mem_rd,
  input  logic            mem_wr,
  output logic [NREG-1:0] rd_sel,
  output logic [NREG-1:0] wr_sel
);
  localparam int unsigned OFF_W = $clog2(NREG);

  logic             port_hit, mem_hit, hit, rd_q, wr_q;
  logic [OFF_W-1:0] off;

  assign port_hit = (bus_addr[PORT_AW-1:OFF_W] == PORT_BASE[PORT_AW-1:OFF_W]);
  assign mem_hit  = (bus_addr[AW-1:OFF_W] == MEM_BASE[AW-1:OFF_W]);
  assign hit      = map_mem ? mem_hit : port_hit;
  assign rd_q     = map_mem ? mem_rd : io_rd;
  assign wr_q     = map_mem ? mem_wr : io_wr;
  assign off      = bus_addr[OFF_W-1:0];

  for (genvar g = 0; g < NREG; g++) begin : g_sel
    assign rd_sel[g] = hit && rd_q && (off == OFF_W'(g));
    assign wr_sel[g] = hit && wr_q && (off == OFF_W'(g));
  end

  p_sel_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rd_sel) && $onehot0(wr_sel));

  p_port_ignores_mem_r2: assert property (@(posedge clk) disable iff (rst)
    (!map_mem && !io_rd && !io_wr) |-> (rd_sel == '0 && wr_sel == '0));

  p_mem_ignores_port_r2: assert property (@(posedge clk) disable iff (rst)
    (map_mem && !mem_rd && !mem_wr) |-> (rd_sel == '0 && wr_sel == '0));
endmodule

// File: rtl/ioc_fifo.sv
module ioc_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          full,
  output logic          empty,
  output logic [LW-1:0] level
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_push) wp <= step(wp);
      if (do_pop)  rp <= step(rp);
      case ({do_push, do_pop})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end

  p_level_bound_r5: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !flush) |=> full);

  p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push) |=> empty);
endmodule

// File: rtl/ioc_xfer_ctrl.sv
module ioc_xfer_ctrl
  import ioc_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned BREQ_AT = 4,
  localparam int unsigned LW     = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctrl_wr,
  input  logic          count_wr,
  input  logic          data_wr,
  input  logic          stat_rd,
  input  logic          data_rd,
  input  logic [DW-1:0] wdata,
  input  logic          dev_online,
  input  logic          dev_in_valid,
  input  logic          dev_out_ready,
  input  logic          fifo_full,
  input  logic          fifo_empty,
  input  logic [LW-1:0] fifo_level,
  output logic          fifo_push,
  output logic          fifo_pop,
  output logic          fifo_flush,
  output logic          push_from_dev,
  output logic          data_rd_ok,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] cnt_q,
  output logic [DW-1:0] status,
  output logic          dev_in_ready,
  output logic          dev_out_valid,
  output logic          breq,
  output logic          irq
);
  dir_e          dir_q;
  logic [DW-1:0] req_q;
  logic          busy_q, done_q, err_q, ovr_q, unr_q, irq_q;
  logic          dir_in, dir_out, start, reject, finish, dec, moved;
  logic          dev_push, cpu_push, cpu_pop, dev_pop, ovr_ev, unr_ev;
  cmd_e          cmd;

  always_comb begin
    dir_in   = (dir_q == DIR_IN);
    dir_out  = (dir_q == DIR_OUT);
    cmd      = cmd_e'(wdata[1:0]);
    start    = ctrl_wr && !busy_q;
    reject   = ctrl_wr && busy_q;
    dev_push = dev_in_valid && busy_q && dir_in && !fifo_full;
    cpu_push = data_wr && dir_out && !fifo_full;
    ovr_ev   = (dev_in_valid && busy_q && dir_in && fifo_full) ||
               (data_wr && dir_out && fifo_full);
    cpu_pop  = data_rd && dir_in && !fifo_empty;
    dev_pop  = dev_out_ready && dir_out && !fifo_empty;
    unr_ev   = data_rd && dir_in && fifo_empty;
    moved    = dir_in ? dev_push : dev_pop;
    dec      = busy_q && (cnt_q != '0) && moved;
    finish   = busy_q && (cnt_q == '0);
  end

  assign fifo_push     = dev_push || cpu_push;
  assign fifo_pop      = cpu_pop || dev_pop;
  assign fifo_flush    = start;
  assign push_from_dev = dir_in;
  assign data_rd_ok    = dir_in && !fifo_empty;
  assign dev_in_ready  = busy_q && dir_in && !fifo_full;
  assign dev_out_valid = dir_out && !fifo_empty;
  assign breq          = dir_in && ((fifo_level >= LW'(BREQ_AT)) ||
                                    ((cnt_q == '0) && !fifo_empty));
  assign irq           = irq_q;

  always_comb begin
    status           = '0;
    status[ST_READY] = dev_online;
    status[ST_DONE]  = done_q;
    status[ST_ERR]   = err_q;
    status[ST_OVR]   = ovr_q;
    status[ST_UNR]   = unr_q;
    status[ST_BUSY]  = busy_q;
    status[ST_IRQ]   = irq_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= DIR_NONE;
      req_q  <= '0;
      cnt_q  <= '0;
      ctrl_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      ovr_q  <= 1'b0;
      unr_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (count_wr) req_q <= wdata;
      if (start) begin
        ctrl_q <= wdata;
        unique case (cmd)
          CMD_IN: begin
            busy_q <= 1'b1; dir_q <= DIR_IN;  cnt_q <= req_q; done_q <= 1'b0;
          end
          CMD_OUT: begin
            busy_q <= 1'b1; dir_q <= DIR_OUT; cnt_q <= req_q; done_q <= 1'b0;
          end
          CMD_CHECK: begin
            busy_q <= 1'b0; dir_q <= DIR_NONE; cnt_q <= '0; done_q <= 1'b1;
          end
          default: begin
            busy_q <= 1'b0; dir_q <= DIR_NONE; cnt_q <= '0; done_q <= 1'b0;
          end
        endcase
      end else begin
        if (dec) cnt_q <= cnt_q - DW'(1);
        if (finish) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
      err_q <= (err_q && !stat_rd) || reject || ovr_ev || unr_ev;
      ovr_q <= (ovr_q && !stat_rd) || ovr_ev;
      unr_q <= (unr_q && !stat_rd) || unr_ev;
      irq_q <= (irq_q && !stat_rd) || finish || ovr_ev || unr_ev ||
               (start && cmd == CMD_CHECK);
    end
  end

  p_cnt_step_r4: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cnt_q != '0 && moved) |=> (cnt_q == $past(cnt_q) - DW'(1)));

  p_done_at_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cnt_q == '0) |=> (done_q && !busy_q));

  p_irq_with_done_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> irq_q);

  p_busy_reject_r9: assert property (@(posedge clk) disable iff (rst)
    (busy_q && ctrl_wr) |=> (err_q && $stable(ctrl_q)));

  p_ovr_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (ovr_q && !stat_rd) |=> ovr_q);

  p_stat_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !dev_in_valid) |=> (!ovr_q && !unr_q));
endmodule

// File: rtl/ioc_regif.sv
module ioc_regif
  import ioc_pkg::*;
#(
  parameter int unsigned   AW        = 16,
  parameter int unsigned   DW        = 8,
  parameter int unsigned   PORT_AW   = 8,
  parameter int unsigned   DEPTH     = 8,
  parameter int unsigned   BREQ_AT   = 4,
  parameter logic [AW-1:0] PORT_BASE = 16'h0040,
  parameter logic [AW-1:0] MEM_BASE  = 16'hC000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          map_mem,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          io_rd,
  input  logic          io_wr,
  input  logic          mem_rd,
  input  logic          mem_wr,
  input  logic          dev_online,
  input  logic          dev_in_valid,
  input  logic [DW-1:0] dev_in_data,
  output logic          dev_in_ready,
  output logic          dev_out_valid,
  output logic [DW-1:0] dev_out_data,
  input  logic          dev_out_ready,
  output logic [3:0]    dev_sel,
  output logic [1:0]    dev_mode,
  output logic          breq,
  output logic          irq
);
  localparam int unsigned LW = $clog2(DEPTH + 1);

  logic [NREG-1:0] rd_sel, wr_sel;
  logic [DW-1:0]   ctrl_q, cnt_q, status, fifo_dout, fifo_din;
  logic [LW-1:0]   fifo_level;
  logic            fifo_full, fifo_empty, fifo_push, fifo_pop, fifo_flush;
  logic            push_from_dev, data_rd_ok;

  ioc_addr_dec #(
    .AW(AW), .PORT_AW(PORT_AW), .PORT_BASE(PORT_BASE), .MEM_BASE(MEM_BASE)
  ) u_dec (
    .clk(clk), .rst(rst), .map_mem(map_mem), .bus_addr(bus_addr),
    .io_rd(io_rd), .io_wr(io_wr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .rd_sel(rd_sel), .wr_sel(wr_sel)
  );

  assign fifo_din = push_from_dev ? dev_in_data : bus_wdata;

  ioc_fifo #(.W(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .flush(fifo_flush), .push(fifo_push),
    .din(fifo_din), .pop(fifo_pop), .dout(fifo_dout),
    .full(fifo_full), .empty(fifo_empty), .level(fifo_level)
  );

  ioc_xfer_ctrl #(.DW(DW), .DEPTH(DEPTH), .BREQ_AT(BREQ_AT)) u_xfer (
    .clk(clk), .rst(rst),
    .ctrl_wr(wr_sel[OFF_CTRL]), .count_wr(wr_sel[OFF_COUNT]),
    .data_wr(wr_sel[OFF_DATA]), .stat_rd(rd_sel[OFF_STAT]),
    .data_rd(rd_sel[OFF_DATA]), .wdata(bus_wdata),
    .dev_online(dev_online), .dev_in_valid(dev_in_valid),
    .dev_out_ready(dev_out_ready), .fifo_full(fifo_full),
    .fifo_empty(fifo_empty), .fifo_level(fifo_level),
    .fifo_push(fifo_push), .fifo_pop(fifo_pop), .fifo_flush(fifo_flush),
    .push_from_dev(push_from_dev), .data_rd_ok(data_rd_ok),
    .ctrl_q(ctrl_q), .cnt_q(cnt_q), .status(status),
    .dev_in_ready(dev_in_ready), .dev_out_valid(dev_out_valid),
    .breq(breq), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (1'b1)
      rd_sel[OFF_CTRL]:  bus_rdata = ctrl_q;
      rd_sel[OFF_COUNT]: bus_rdata = cnt_q;
      rd_sel[OFF_STAT]:  bus_rdata = status;
      rd_sel[OFF_DATA]:  bus_rdata = data_rd_ok ? fifo_dout : '0;
      default:           bus_rdata = '0;
    endcase
  end

  assign dev_out_data = fifo_dout;
  assign dev_mode     = ctrl_q[3:2];
  assign dev_sel      = ctrl_q[7:4];

  p_irq_reset_r11: assert property (@(posedge clk) rst |=> (!irq && !breq));
endmodule

// File: tb/ioc_regif_tb.sv
module ioc_regif_tb;
  localparam logic [15:0] P = 16'h0040;
  localparam logic [15:0] M = 16'hC000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic map_mem = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic io_rd = 0, io_wr = 0, mem_rd = 0, mem_wr = 0;
  logic dev_online = 1'b1, dev_in_valid = 1'b0, dev_out_ready = 1'b0;
  logic [7:0] dev_in_data = '0, dev_out_data;
  logic dev_in_ready, dev_out_valid, breq, irq;
  logic [3:0] dev_sel;
  logic [1:0] dev_mode;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  ioc_regif u_dut (
    .clk(clk), .rst(rst), .map_mem(map_mem), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .io_rd(io_rd),
    .io_wr(io_wr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .dev_online(dev_online), .dev_in_valid(dev_in_valid),
    .dev_in_data(dev_in_data), .dev_in_ready(dev_in_ready),
    .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data),
    .dev_out_ready(dev_out_ready), .dev_sel(dev_sel), .dev_mode(dev_mode),
    .breq(breq), .irq(irq)
  );

  // behavioural reference model
  logic [7:0] mq[$];
  int   m_cnt, m_req, m_dir;
  bit   m_busy, m_done, m_err, m_ovr, m_unr, m_irq;
  logic [7:0] m_ctrl;

  function automatic bit m_hit();
    return map_mem ? (bus_addr[15:2] == M[15:2]) : (bus_addr[7:2] == P[7:2]);
  endfunction

  function automatic logic [7:0] m_status();
    return {m_irq, 1'b0, m_busy, m_unr, m_ovr, m_err, m_done, dev_online};
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    bit rd, h; int off; logic [7:0] er;
    rd = map_mem ? mem_rd : io_rd;
    h = m_hit(); off = int'(bus_addr[1:0]);
    er = 8'h00;
    if (rd && h) begin
      case (off)
        0: er = m_ctrl;
        1: er = 8'(m_cnt);
        2: er = m_status();
        default: er = (m_dir == 1 && mq.size() > 0) ? mq[0] : 8'h00;
      endcase
    end
    chk("R1 bus_rdata", bus_rdata, er);
    chk("R12 dev_in_ready", 8'(dev_in_ready),
        8'(m_busy && m_dir == 1 && mq.size() < 8));
    chk("R12 dev_out_valid", 8'(dev_out_valid), 8'(m_dir == 2 && mq.size() > 0));
    if (m_dir == 2 && mq.size() > 0) chk("R12 dev_out_data", dev_out_data, mq[0]);
    chk("R10 breq", 8'(breq),
        8'(m_dir == 1 && (mq.size() >= 4 || (m_cnt == 0 && mq.size() > 0))));
    chk("R7 irq", 8'(irq), 8'(m_irq));
    chk("R3 dev_sel", 8'(dev_sel), 8'(m_ctrl[7:4]));
    chk("R3 dev_mode", 8'(dev_mode), 8'(m_ctrl[3:2]));
  endtask

  task automatic model_edge();
    bit rd, wr, h, wctl, wcnt, wdat, rstat, rdat, full, empty;
    bit push_d, push_c, pop_c, pop_d, ovr_e, unr_e, fin, dec, rej;
    int off;
    if (rst) begin
      mq.delete(); m_cnt = 0; m_req = 0; m_dir = 0; m_busy = 0; m_done = 0;
      m_err = 0; m_ovr = 0; m_unr = 0; m_irq = 0; m_ctrl = 8'h00;
      return;
    end
    rd = map_mem ? mem_rd : io_rd; wr = map_mem ? mem_wr : io_wr;
    h = m_hit(); off = int'(bus_addr[1:0]);
    wctl = wr && h && off == 0; wcnt = wr && h && off == 1;
    wdat = wr && h && off == 3; rstat = rd && h && off == 2;
    rdat = rd && h && off == 3;
    full = (mq.size() == 8); empty = (mq.size() == 0);
    push_d = dev_in_valid && m_busy && m_dir == 1 && !full;
    push_c = wdat && m_dir == 2 && !full;
    ovr_e  = (dev_in_valid && m_busy && m_dir == 1 && full) || (wdat && m_dir == 2 && full);
    pop_c  = rdat && m_dir == 1 && !empty;
    pop_d  = dev_out_ready && m_dir == 2 && !empty;
    unr_e  = rdat && m_dir == 1 && empty;
    dec    = m_busy && m_cnt != 0 && (m_dir == 1 ? push_d : pop_d);
    fin    = m_busy && m_cnt == 0;
    rej    = wctl && m_busy;
    if (rstat) begin m_irq = 0; m_err = 0; m_ovr = 0; m_unr = 0; end
    if (wctl && !m_busy) begin
      int cmd = int'(bus_wdata[1:0]);
      mq.delete(); m_ctrl = bus_wdata;
      if (cmd == 1 || cmd == 2) begin
        m_busy = 1; m_dir = cmd; m_cnt = m_req; m_done = 0;
      end else begin
        m_busy = 0; m_dir = 0; m_cnt = 0; m_done = (cmd == 3);
        if (cmd == 3) m_irq = 1;
      end
    end else begin
      if (pop_c || pop_d) void'(mq.pop_front());
      if (push_d) mq.push_back(dev_in_data);
      if (push_c) mq.push_back(bus_wdata);
      if (dec) m_cnt--;
      if (fin) begin m_busy = 0; m_done = 1; end
    end
    if (wcnt) m_req = int'(bus_wdata);
    if (rej || ovr_e || unr_e) m_err = 1;
    if (ovr_e) m_ovr = 1;
    if (unr_e) m_unr = 1;
    if (fin || ovr_e || unr_e) m_irq = 1;
  endtask

  task automatic cycle();
    #1 compare();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic raw(bit use_mem, bit r, bit w, logic [15:0] a, logic [7:0] d,
                     output logic [7:0] got);
    bus_addr = a; bus_wdata = d;
    if (use_mem) begin mem_rd = r; mem_wr = w; end
    else begin io_rd = r; io_wr = w; end
    #1 got = bus_rdata;
    cycle();
    io_rd = 0; io_wr = 0; mem_rd = 0; mem_wr = 0;
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    logic [7:0] g;
    raw(map_mem, 1'b0, 1'b1, a, d, g);
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] g);
    raw(map_mem, 1'b1, 1'b0, a, 8'h00, g);
  endtask

  initial begin
    #(100000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] g, junk;
    @(negedge clk);
    idle(3);
    rst = 0;
    // R11: reset state
    rd(P + 2, g); chk("R11 status after reset", g, 8'h01);
    rd(P + 1, g); chk("R11 count after reset", g, 8'h00);

    // R1: upper bits ignored in port mode; R2: mem strobe ignored in port mode
    wr(16'h7F41, 8'd5);
    raw(1'b1, 1'b0, 1'b1, 16'h0041, 8'd7, junk);
    wr(P + 0, 8'hA5);
    rd(P + 1, g); chk("R1 R2 count loaded", g, 8'd5);
    chk("R3 dev_sel field", 8'(dev_sel), 8'h0A);

    // R12/R4/R10: inbound, five words back to back
    for (int i = 0; i < 5; i++) begin
      dev_in_valid = 1; dev_in_data = 8'h10 + 8'(i); cycle();
    end
    dev_in_valid = 0;
    chk("R10 breq at five words", 8'(breq), 8'h01);
    idle(1);
    rd(P + 2, g); chk("R4 done and irq", g & 8'h82, 8'h82);
    chk("R8 irq cleared by status read", 8'(irq), 8'h00);
    for (int i = 0; i < 5; i++) begin
      rd(P + 3, g); chk("R12 inbound order", g, 8'h10 + 8'(i));
    end
    chk("R10 breq drops when empty", 8'(breq), 8'h00);
    rd(P + 3, g); chk("R6 empty read returns zero", g, 8'h00);
    rd(P + 2, g); chk("R6 underrun flag", g & 8'h14, 8'h14);

    // R9: command while busy
    wr(P + 1, 8'd2); wr(P + 0, 8'h31);
    wr(P + 0, 8'h72);
    rd(P + 0, g); chk("R9 command unchanged", g, 8'h31);
    rd(P + 2, g); chk("R9 error set while busy", g & 8'h24, 8'h24);
    dev_in_valid = 1; dev_in_data = 8'h21; cycle(); dev_in_data = 8'h22; cycle();
    dev_in_valid = 0; idle(2);

    // R2: memory mode, port strobe and out-of-window ignored
    map_mem = 1;
    raw(1'b0, 1'b0, 1'b1, M + 1, 8'd7, junk);
    wr(16'h0041, 8'd9);
    wr(M + 0, 8'h02);
    rd(M + 1, g); chk("R2 count unaffected by ignored writes", g, 8'd2);

    // R5: processor overfills outbound buffer
    for (int i = 0; i < 9; i++) wr(M + 3, 8'h30 + 8'(i));
    rd(M + 2, g); chk("R5 outbound overrun", g & 8'h0C, 8'h0C);
    chk("R12 outbound head", dev_out_data, 8'h30);
    dev_out_ready = 1; idle(3); dev_out_ready = 0;
    rd(M + 2, g); chk("R4 outbound done", g & 8'h22, 8'h02);

    // R5: device overrun inbound
    wr(M + 1, 8'd12); wr(M + 0, 8'h01);
    for (int i = 0; i < 10; i++) begin
      dev_in_valid = 1; dev_in_data = 8'h50 + 8'(i); cycle();
    end
    dev_in_valid = 0;
    rd(M + 2, g); chk("R5 device overrun", g & 8'h0C, 8'h0C);
    rd(M + 2, g); chk("R8 sticky flags cleared", g, 8'h21);
    rd(M + 1, g); chk("R4 remaining count", g, 8'd4);
    chk("R10 breq with full buffer", 8'(breq), 8'h01);

    // R11: reset with a full buffer
    rst = 1; idle(1);
    chk("R11 breq low after reset", 8'(breq), 8'h00);
    chk("R11 irq low after reset", 8'(irq), 8'h00);
    rst = 0;

    // R3: check command, zero count, clear
    wr(M + 0, 8'h03);
    rd(M + 2, g); chk("R3 check sets done and irq", g, 8'h83);
    wr(M + 1, 8'd0); wr(M + 0, 8'h01); idle(1);
    rd(M + 2, g); chk("R4 zero count finishes", g & 8'h22, 8'h02);
    wr(M + 0, 8'h00);
    rd(M + 2, g); chk("R3 clear drops done", g & 8'h02, 8'h00);
    dev_online = 0; idle(1);
    rd(M + 2, g); chk("R7 ready follows device", g & 8'h01, 8'h00);
    idle(2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule